// File: doc/BRIEF.md
# Request Byte-Enable Rule Checker

This block judges the two byte-enable fields of one already decoded request per clock. A request is described by its kind, its length in doublewords, address bit 2, a steering-hint flag and its first and last 4-bit byte-enable fields. The block registers four results: the byte masks a completer should apply, a malformed flag with a reason code, a no-effect flag for empty one-doubleword writes, and a flush flag for empty one-doubleword reads. Whether a gap between enabled bytes is legal depends on the length and on quadword alignment. A memory read that carries the hint flag has its raw fields replaced by implied all-ones masks.

The result path is a two-state machine. In `ST_EMPTY` no result is presented. A request accepted with `in_valid` moves it to `ST_RESULT` (transition *accept*), and a further request in that state keeps it there (transition *chain*). A cycle without a request sends it back to `ST_EMPTY` (transition *drain*). In any other case the machine holds its state (transition *wait*). `out_valid` is high exactly while the machine is in `ST_RESULT`. The result registers load only on accepted requests. The `chk_en` input turns rule checking off without affecting the masks.

Top module: `be_rule_check`

## Requirements
- R1: The result for a request accepted with `in_valid` high appears on the outputs one clock later, with `out_valid` high for exactly that cycle. `out_valid` is low in any cycle that does not follow an accepted request.
- R2: Take a request that is not a hinted memory read. If its length is 1 and the last field is not 0000b, it is reported malformed with reason code 1.
- R3: Take a request that is not a hinted memory read and whose length is not 1 (a length field of 0 means 1024). If its first or last field is 0000b, it is reported malformed with reason code 2. Reason 2 takes precedence over reason 3.
- R4: At length 1, any first-field pattern, including gapped ones such as 1010b or 1001b, is legal (reason 0) when the last field is 0000b.
- R5: A memory read (kind 0) or memory write (kind 1) of length 2 with address bit 2 equal to 0 may have gaps in both fields and is legal.
- R6: A memory request of length 2 with address bit 2 equal to 1, or of length 3 or more, is legal only in one case. The enabled bits of the first field must run unbroken up to bit 3, and those of the last field must run unbroken from bit 0. Any other pattern gives reason code 3.
- R7: A memory read with the hint flag set is never malformed. Its effective masks are first=1111b and last=0000b at length 1, and 1111b for both at any other length. On any other kind the hint flag is ignored: the raw fields pass through and are checked as usual.
- R8: A memory write of length 1 with a first field of 0000b sets `out_no_effect` and is not malformed.
- R9: A memory read of length 1 without the hint flag and with a first field of 0000b sets `out_flush` and is not malformed.
- R10: When `chk_en` is low, `out_malformed` is 0 and `out_reason` is 0. The effective masks and the two flags are still produced.
- R11: I/O requests (kind 2) and configuration requests (kind 3) get no contiguity check, so gapped fields at length 2 are legal for them.
- R12: After reset, `out_valid` and `out_malformed` are 0 and `out_reason` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_en | input | 1 | Rule checking on (1) or off (0) |
| in_valid | input | 1 | A request is present this cycle |
| in_kind | input | 2 | 0 memory read, 1 memory write, 2 I/O, 3 configuration |
| in_len | input | LEN_W | Length in doublewords; 0 means 1024 |
| in_addr_b2 | input | 1 | Address bit 2; 0 means quadword aligned |
| in_hint | input | 1 | Steering-hint flag |
| in_first | input | BE_W | First doubleword byte enables |
| in_last | input | BE_W | Last doubleword byte enables |
| out_valid | output | 1 | Result present |
| out_first | output | BE_W | Effective first byte enables |
| out_last | output | BE_W | Effective last byte enables |
| out_malformed | output | 1 | Request breaks a byte-enable rule |
| out_reason | output | 2 | 0 ok, 1 last set at length 1, 2 empty field at length above 1, 3 gap |
| out_no_effect | output | 1 | Empty one-doubleword write |
| out_flush | output | 1 | Empty one-doubleword read |

## Verification
The bench builds the block with its default parameters: a 10-bit length and 4-bit byte-enable fields. The 10-bit length makes the value 0 reachable, so the bench can confirm that this value is treated as 1024 doublewords and falls under the multi-doubleword rules. The 4-bit field width lets every anchored and gapped pattern named in the requirements be driven directly. Back-to-back requests exercise the *chain* transition, and idle gaps exercise the *drain* transition.

// File: rtl/be_chk_pkg.sv
package be_chk_pkg;

    // Request kinds as seen on in_kind
    typedef enum logic [1:0] {
        KIND_MRD = 2'd0,
        KIND_MWR = 2'd1,
        KIND_IO  = 2'd2,
        KIND_CFG = 2'd3
    } req_kind_e;

    // Reason codes as seen on out_reason
    typedef enum logic [1:0] {
        WHY_OK         = 2'd0,
        WHY_LAST_SET   = 2'd1,
        WHY_ZERO_FIELD = 2'd2,
        WHY_GAP        = 2'd3
    } why_e;

    // Result presentation states
    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_RESULT = 1'b1
    } out_state_e;

endpackage

// File: rtl/be_len_decode.sv
module be_len_decode #(
    parameter int LEN_W = 10
) (
    input  logic [LEN_W-1:0] len,
    output logic             len_one,
    output logic             len_two
);
    // A length field of zero stands for the largest size and so is neither
    // one nor two doublewords.
    assign len_one = (len == LEN_W'(1));
    assign len_two = (len == LEN_W'(2));
endmodule

// File: rtl/be_run_check.sv
module be_run_check #(
    parameter int BE_W       = 4,
    parameter bit TOP_ANCHOR = 1'b1
) (
    input  logic [BE_W-1:0] field,
    output logic            is_run
);
    generate
        if (TOP_ANCHOR) begin : g_top
            // Set bits must form one run ending at the top bit: the inverse
            // is then a run starting at bit 0.
            logic [BE_W-1:0] inv;
            assign inv    = ~field;
            assign is_run = ((inv & (inv + BE_W'(1))) == '0);
        end else begin : g_bot
            // Set bits must form one run starting at bit 0.
            assign is_run = ((field & (field + BE_W'(1))) == '0);
        end
    endgenerate
endmodule

// File: rtl/be_rule_eval.sv
module be_rule_eval
    import be_chk_pkg::*;
#(
    parameter int BE_W = 4
) (
    input  req_kind_e       kind,
    input  logic            len_one,
    input  logic            len_two,
    input  logic            addr_b2,
    input  logic            hint,
    input  logic            chk_en,
    input  logic [BE_W-1:0] first,
    input  logic [BE_W-1:0] last,
    output logic [BE_W-1:0] eff_first,
    output logic [BE_W-1:0] eff_last,
    output why_e            why,
    output logic            no_effect,
    output logic            flush
);
    logic [BE_W-1:0] fld    [2];
    logic            run_ok [2];
    logic            hint_rd;
    logic            is_mem;
    logic            gaps_ok;
    why_e            why_raw;

    assign fld[0] = first;
    assign fld[1] = last;

    // Field 0 must reach its top byte, field 1 must start at its bottom byte
    for (genvar g = 0; g < 2; g++) begin : g_field
        be_run_check #(
            .BE_W      (BE_W),
            .TOP_ANCHOR(g == 0)
        ) u_run (
            .field (fld[g]),
            .is_run(run_ok[g])
        );
    end

    assign hint_rd = (kind == KIND_MRD) && hint;
    assign is_mem  = (kind == KIND_MRD) || (kind == KIND_MWR);
    assign gaps_ok = !is_mem || (len_two && !addr_b2);

    always_comb begin
        if (hint_rd) begin
            eff_first = '1;
            eff_last  = len_one ? '0 : '1;
        end else begin
            eff_first = first;
            eff_last  = last;
        end
    end

    always_comb begin
        why_raw = WHY_OK;
        if (hint_rd) begin
            why_raw = WHY_OK;
        end else if (len_one) begin
            if (last != '0) why_raw = WHY_LAST_SET;
        end else if ((first == '0) || (last == '0)) begin
            why_raw = WHY_ZERO_FIELD;
        end else if (!gaps_ok && !(run_ok[0] && run_ok[1])) begin
            why_raw = WHY_GAP;
        end
    end

    assign why       = chk_en ? why_raw : WHY_OK;
    assign no_effect = (kind == KIND_MWR) && len_one && (first == '0);
    assign flush     = (kind == KIND_MRD) && !hint && len_one && (first == '0);
endmodule

// File: rtl/be_rule_check.sv
module be_rule_check
    import be_chk_pkg::*;
#(
    parameter int LEN_W = 10,
    parameter int BE_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_en,
    input  logic             in_valid,
    input  logic [1:0]       in_kind,
    input  logic [LEN_W-1:0] in_len,
    input  logic             in_addr_b2,
    input  logic             in_hint,
    input  logic [BE_W-1:0]  in_first,
    input  logic [BE_W-1:0]  in_last,
    output logic             out_valid,
    output logic [BE_W-1:0]  out_first,
    output logic [BE_W-1:0]  out_last,
    output logic             out_malformed,
    output logic [1:0]       out_reason,
    output logic             out_no_effect,
    output logic             out_flush
);
    out_state_e      state, state_nxt;
    logic            len_one, len_two;
    logic [BE_W-1:0] c_first, c_last;
    why_e            c_why;
    logic            c_no_effect, c_flush;

    be_len_decode #(.LEN_W(LEN_W)) u_len (
        .len    (in_len),
        .len_one(len_one),
        .len_two(len_two)
    );

    be_rule_eval #(.BE_W(BE_W)) u_eval (
        .kind     (req_kind_e'(in_kind)),
        .len_one  (len_one),
        .len_two  (len_two),
        .addr_b2  (in_addr_b2),
        .hint     (in_hint),
        .chk_en   (chk_en),
        .first    (in_first),
        .last     (in_last),
        .eff_first(c_first),
        .eff_last (c_last),
        .why      (c_why),
        .no_effect(c_no_effect),
        .flush    (c_flush)
    );

    // Next state: accept, chain, drain or wait
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_EMPTY:  if (in_valid) state_nxt = ST_RESULT;
            ST_RESULT: if (!in_valid) state_nxt = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nxt;
    end

    // Result registers load only on an accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_first     <= '0;
            out_last      <= '0;
            out_malformed <= 1'b0;
            out_reason    <= 2'd0;
            out_no_effect <= 1'b0;
            out_flush     <= 1'b0;
        end else if (in_valid) begin
            out_first     <= c_first;
            out_last      <= c_last;
            out_malformed <= (c_why != WHY_OK);
            out_reason    <= c_why;
            out_no_effect <= c_no_effect;
            out_flush     <= c_flush;
        end
    end

    assign out_valid = (state == ST_RESULT);
endmodule

// File: rtl/be_rule_check_sva.sv
module be_rule_check_sva #(
    parameter int LEN_W = 10,
    parameter int BE_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             chk_en,
    input logic             in_valid,
    input logic [1:0]       in_kind,
    input logic [LEN_W-1:0] in_len,
    input logic             in_hint,
    input logic [BE_W-1:0]  in_first,
    input logic [BE_W-1:0]  in_last,
    input logic             out_valid,
    input logic [BE_W-1:0]  out_first,
    input logic             out_malformed,
    input logic [1:0]       out_reason
);
    logic hint_rd;
    assign hint_rd = (in_kind == 2'd0) && in_hint;

    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    p_last_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && chk_en && !hint_rd && (in_len == LEN_W'(1)) && (in_last != '0))
        |-> (out_malformed && out_reason == 2'd1));

    p_zero_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && chk_en && !hint_rd && (in_len != LEN_W'(1)) &&
              ((in_first == '0) || (in_last == '0)))
        |-> (out_malformed && out_reason == 2'd2));

    p_hint_masks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && hint_rd) |-> ((out_first == '1) && !out_malformed));

    p_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && !chk_en) |-> (!out_malformed && out_reason == 2'd0));

    p_flag_code_r12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_malformed == (out_reason != 2'd0)));
endmodule

bind be_rule_check be_rule_check_sva #(.LEN_W(LEN_W), .BE_W(BE_W)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .chk_en       (chk_en),
    .in_valid     (in_valid),
    .in_kind      (in_kind),
    .in_len       (in_len),
    .in_hint      (in_hint),
    .in_first     (in_first),
    .in_last      (in_last),
    .out_valid    (out_valid),
    .out_first    (out_first),
    .out_malformed(out_malformed),
    .out_reason   (out_reason)
);

// File: tb/be_rule_check_test.sv
`timescale 1ns/1ps
module be_rule_check_test;
    localparam int LEN_W = 10;
    localparam int BE_W  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             chk_en = 1'b1;
    logic             in_valid = 1'b0;
    logic [1:0]       in_kind = 2'd0;
    logic [LEN_W-1:0] in_len = '0;
    logic             in_addr_b2 = 1'b0;
    logic             in_hint = 1'b0;
    logic [BE_W-1:0]  in_first = '0;
    logic [BE_W-1:0]  in_last = '0;
    logic             out_valid;
    logic [BE_W-1:0]  out_first, out_last;
    logic             out_malformed;
    logic [1:0]       out_reason;
    logic             out_no_effect, out_flush;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Expected item: {malformed, reason[1:0], first[3:0], last[3:0], no_effect, flush}
    logic [12:0] exp_q [$];
    string       tag_q [$];

    be_rule_check #(.LEN_W(LEN_W), .BE_W(BE_W)) uut (
        .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .in_valid(in_valid),
        .in_kind(in_kind), .in_len(in_len), .in_addr_b2(in_addr_b2),
        .in_hint(in_hint), .in_first(in_first), .in_last(in_last),
        .out_valid(out_valid), .out_first(out_first), .out_last(out_last),
        .out_malformed(out_malformed), .out_reason(out_reason),
        .out_no_effect(out_no_effect), .out_flush(out_flush)
    );

    always #10 clk = ~clk;

    function automatic logic [12:0] model(input logic [1:0] k, input logic [LEN_W-1:0] n,
                                          input logic b2, input logic h,
                                          input logic [3:0] f, input logic [3:0] l,
                                          input logic en);
        logic [3:0] ef, el;
        logic [1:0] why;
        bit hr, top_ok, bot_ok, seen;
        hr = (k == 2'd0) && h;
        ef = hr ? 4'b1111 : f;
        el = hr ? ((n == 1) ? 4'b0000 : 4'b1111) : l;
        // first field: once a set bit is seen going upward, all higher bits set
        top_ok = 1'b1; seen = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (f[i]) seen = 1'b1;
            else if (seen) top_ok = 1'b0;
        end
        // last field: once a set bit is seen going downward, all lower bits set
        bot_ok = 1'b1; seen = 1'b0;
        for (int i = 3; i >= 0; i--) begin
            if (l[i]) seen = 1'b1;
            else if (seen) bot_ok = 1'b0;
        end
        why = 2'd0;
        if (!hr) begin
            if (n == 1) begin
                if (l != 0) why = 2'd1;
            end else if (f == 0 || l == 0) begin
                why = 2'd2;
            end else if (k <= 2'd1 && !(n == 2 && !b2) && !(top_ok && bot_ok)) begin
                why = 2'd3;
            end
        end
        if (!en) why = 2'd0;
        return {why != 2'd0, why, ef, el,
                (k == 2'd1) && (n == 1) && (f == 0),
                (k == 2'd0) && !h && (n == 1) && (f == 0)};
    endfunction

    task automatic send(input string tag, input logic [1:0] k, input logic [LEN_W-1:0] n,
                        input logic b2, input logic h, input logic [3:0] f,
                        input logic [3:0] l, input logic en);
        in_valid = 1'b1; in_kind = k; in_len = n; in_addr_b2 = b2;
        in_hint = h; in_first = f; in_last = l; chk_en = en;
        exp_q.push_back(model(k, n, b2, h, f, l, en));
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic idle(input int cycles);
        in_valid = 1'b0;
        in_first = 4'b1010; in_last = 4'b0101; in_hint = 1'b1;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R1 unexpected out_valid", 13'h1, 13'h0);
            end else begin
                check(tag_q.pop_front(),
                      {out_malformed, out_reason, out_first, out_last, out_no_effect, out_flush},
                      exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12 reset", {out_valid, out_malformed, out_reason}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 after release", {out_valid, out_malformed, out_reason}, 4'b0000);

        send("R2 last set len1",          2'd1, 10'd1, 1'b0, 1'b0, 4'b1111, 4'b0001, 1'b1);
        send("R4 gap first len1 wr",      2'd1, 10'd1, 1'b0, 1'b0, 4'b1010, 4'b0000, 1'b1);
        send("R4 gap first len1 rd",      2'd0, 10'd1, 1'b1, 1'b0, 4'b1001, 4'b0000, 1'b1);
        idle(2);
        check("R1 idle out_valid", {12'h0, out_valid}, 13'h0);
        send("R3 zero first len2",        2'd1, 10'd2, 1'b0, 1'b0, 4'b0000, 4'b1111, 1'b1);
        send("R3 len0 is 1024 zero last", 2'd0, 10'd0, 1'b0, 1'b0, 4'b1111, 4'b0000, 1'b1);
        send("R3 zero beats gap",         2'd1, 10'd4, 1'b1, 1'b0, 4'b0000, 4'b0101, 1'b1);
        send("R5 aligned len2 gaps",      2'd1, 10'd2, 1'b0, 1'b0, 4'b0101, 4'b1010, 1'b1);
        send("R6 misaligned len2 gaps",   2'd1, 10'd2, 1'b1, 1'b0, 4'b0101, 4'b1010, 1'b1);
        idle(1);
        send("R6 len3 runs 1100/0011",    2'd0, 10'd3, 1'b0, 1'b0, 4'b1100, 4'b0011, 1'b1);
        send("R6 len3 runs 1000/0111",    2'd1, 10'd3, 1'b1, 1'b0, 4'b1000, 4'b0111, 1'b1);
        send("R6 first gap 1011",         2'd1, 10'd3, 1'b0, 1'b0, 4'b1011, 4'b0011, 1'b1);
        send("R6 last not at bottom 1110",2'd0, 10'd5, 1'b0, 1'b0, 4'b1100, 4'b1110, 1'b1);
        send("R6 len0 first not at top",  2'd1, 10'd0, 1'b0, 1'b0, 4'b0011, 4'b1111, 1'b1);
        send("R6 misaligned len2 runs",   2'd0, 10'd2, 1'b1, 1'b0, 4'b1110, 4'b0001, 1'b1);
        idle(3);
        send("R7 hint rd len1",           2'd0, 10'd1, 1'b0, 1'b1, 4'b0000, 4'b0101, 1'b1);
        send("R7 hint rd len5",           2'd0, 10'd5, 1'b1, 1'b1, 4'b0000, 4'b0000, 1'b1);
        send("R7 hint ignored on write",  2'd1, 10'd3, 1'b0, 1'b1, 4'b1010, 4'b0101, 1'b1);
        send("R8 empty write len1",       2'd1, 10'd1, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b1);
        send("R9 flush read len1",        2'd0, 10'd1, 1'b1, 1'b0, 4'b0000, 4'b0000, 1'b1);
        idle(1);
        send("R10 disabled last set",     2'd1, 10'd1, 1'b0, 1'b0, 4'b1111, 4'b1111, 1'b0);
        send("R10 disabled gap",          2'd1, 10'd3, 1'b0, 1'b0, 4'b0101, 4'b1010, 1'b0);
        send("R10 disabled flush flag",   2'd0, 10'd1, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b0);
        send("R11 io len2 gaps",          2'd2, 10'd2, 1'b1, 1'b0, 4'b1010, 4'b0101, 1'b1);
        send("R11 cfg len1 gap",          2'd3, 10'd1, 1'b0, 1'b0, 4'b0110, 4'b0000, 1'b1);
        send("R11 cfg len3 gaps",         2'd3, 10'd3, 1'b0, 1'b0, 4'b1001, 4'b1001, 1'b1);
        idle(4);
        check("R1 all results seen", {7'h0, 6'(exp_q.size())}, 13'h0);
        check("R1 drained out_valid", {12'h0, out_valid}, 13'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule